// File: doc/BRIEF.md
# DMA Completion Interrupt Router

This block gathers the completion flags of fifteen DMA channels and presents them two ways. The first is a read-only status word with one bit per channel. The second is a set of twelve interrupt lines feeding a small two-level interrupt controller. Channels 0 through 10 each own a line. Channels 11 through 14 are merged onto one shared line.

The controller keeps a per-line enable mask that software sets and clears through separate write offsets. It exposes a first-level pending word, which holds the enabled lines at bit 16 and up. It also exposes a basic pending word, whose bit 8 summarises that bank. The same summary drives `irq_out`.

Pending bits are level-sensitive. They follow the channel flags and drop as soon as a flag drops. Reads go through a one-cycle registered port.

Top module: `dma_irq_router`

## Requirements
- R1: After reset `rvalid` is 0, the enable mask is empty, and with all channel flags low every readable offset (0x000, 0x004, 0x010, 0xFE0) returns 0.
- R2: A read of offset 0xFE0 returns channel n's flag in bit n for n = 0..14; bits 31:15 read 0.
- R3: Channel n, for n = 0..10, drives line n, which appears at bit 16+n of the pending word at offset 0x004 while that line is enabled.
- R4: Channels 11..14 are ORed onto line 11, shown at bit 27 of offset 0x004; any one of them alone sets it.
- R5: A line whose enable bit is clear never shows in offset 0x004; bits 15:0 and 31:28 of that word always read 0.
- R6: A write to offset 0x010 ORs `wdata[27:16]` into the enable mask; other data bits are ignored. A read of 0x010 returns the mask at bits 27:16.
- R7: A write to offset 0x01C clears each enable bit whose `wdata` bit (27:16) is 1 and leaves the others. Offset 0x01C reads 0.
- R8: Bit 8 of offset 0x000 and the output `irq_out` are 1 exactly when some bit of the 0x004 word is 1; all other bits of 0x000 read 0.
- R9: Pending is level-sensitive: lowering a channel flag removes its pending bit with no write from software.
- R10: `rdata` and `rvalid` appear on the cycle after `rd_en` is sampled. Writes to offsets other than 0x010 and 0x01C leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_irq | input | 15 | Completion flag of each DMA channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| irq_out | output | 1 | Summary interrupt to the processor |

## Verification
The routing is exercised with a single dedicated flag at each end of the one-to-one range (channels 0 and 10). It is also exercised with the first and last of the shared group alone, which shows whether line 11 really ORs all four inputs. A flag raised while its line is masked separates the raw status word from the gated pending word. Dropping a flag checks level behaviour. All-ones writes to the enable, disable and pending offsets check that out-of-field bits are discarded and that only the two mask offsets change it.

// File: rtl/dma_irq_router.sv
module dma_irq_router #(
  parameter int NCH   = 15,
  parameter int NDED  = 11,
  parameter int LBASE = 16,
  parameter int SUMB  = 8,
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter logic [AW-1:0] A_BASIC = 'h000,
  parameter logic [AW-1:0] A_PEND  = 'h004,
  parameter logic [AW-1:0] A_EN    = 'h010,
  parameter logic [AW-1:0] A_DIS   = 'h01C,
  parameter logic [AW-1:0] A_STAT  = 'hFE0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NCH-1:0] chan_irq,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          irq_out
);
  localparam int NLINE = NDED + 1;
  localparam int LTOP  = LBASE + NLINE - 1;

  logic [NLINE-1:0] line, en, pend;
  logic [DW-1:0]    rd_mux;

  genvar g;
  generate
    for (g = 0; g < NDED; g++) begin : g_ded
      assign line[g] = chan_irq[g];
    end
  endgenerate
  assign line[NDED] = |chan_irq[NCH-1:NDED];

  assign pend    = line & en;
  assign irq_out = |pend;

  always_ff @(posedge clk) begin
    if (!rst_n) en <= '0;
    else if (wr_en && addr == A_EN)  en <= en | wdata[LTOP:LBASE];
    else if (wr_en && addr == A_DIS) en <= en & ~wdata[LTOP:LBASE];
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_STAT:  rd_mux[NCH-1:0]    = chan_irq;
      A_PEND:  rd_mux[LTOP:LBASE] = pend;
      A_EN:    rd_mux[LTOP:LBASE] = en;
      A_BASIC: rd_mux[SUMB]       = |pend;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R10
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == A_EN || addr == A_DIS)) |=> $stable(en));
  // R6
  enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_EN) |=>
      ((en & $past(wdata[LTOP:LBASE])) == $past(wdata[LTOP:LBASE])));
  // R7
  disable_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIS) |=> ((en & $past(wdata[LTOP:LBASE])) == '0));
  // R8
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (en != '0));
  // R4
  shared_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_irq[NCH-1:NDED] != '0) && en[NDED]) |-> irq_out);
endmodule

// File: tb/test_dma_irq_router.sv
`timescale 1ns/1ps
module test_dma_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] chan_irq = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, irq_out;

  int errs = 0, checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [11:0] en_m = '0;

  always #2 clk = ~clk;

  dma_irq_router i_dma_irq_router (.clk, .rst_n, .chan_irq, .wr_en, .rd_en,
    .addr, .wdata, .rdata, .rvalid, .irq_out);

  function automatic logic [11:0] lines_m();
    logic [11:0] l;
    l[10:0] = chan_irq[10:0];
    l[11]   = |chan_irq[14:11];
    return l;
  endfunction

  function automatic logic [31:0] pend_m();
    return {4'b0, lines_m() & en_m, 16'b0};
  endfunction

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    if (a == 12'h010) en_m = en_m | d[27:16];
    if (a == 12'h01C) en_m = en_m & ~d[27:16];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_irq(input string tag);
    logic e;
    @(negedge clk);
    e = |pend_m();
    checks++;
    if (irq_out !== e) begin
      errs++;
      $display("FAIL %s irq_out actual=%0b expected=%0b", tag, irq_out, e);
    end
  endtask

  task automatic rd_all(input string tag);
    rd(12'hFE0, {17'b0, chan_irq}, {tag, " R2 status"});
    rd(12'h004, pend_m(), {tag, " R3/R5 pending"});
    rd(12'h000, (|pend_m()) ? 32'h100 : 32'h0, {tag, " R8 basic"});
    rd(12'h010, {4'b0, en_m, 16'b0}, {tag, " R6 mask"});
    chk_irq({tag, " R8"});
  endtask

  always @(negedge clk) begin
    if (rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errs++;
        $display("FAIL R10 unexpected rvalid actual=%h expected=none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errs++;
          $display("FAIL %s actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    #400000;
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rvalid !== 1'b0) begin
      errs++;
      $display("FAIL R1 rvalid in reset actual=%b expected=0", rvalid);
    end
    rst_n = 1'b1;
    rd_all("R1 idle");
    rd(12'h01C, 32'h0, "R1 R7 disable reads zero");

    wr(12'h010, 32'h0001_0000);
    rd_all("R1 enabled no flags");
    chan_irq = 15'h0001;
    rd_all("R3 ch0");

    chan_irq = 15'h0020;
    rd_all("R5 ch5 masked");

    wr(12'h010, 32'h0400_0000);
    chan_irq = 15'h0400;
    rd_all("R3 ch10");

    wr(12'h010, 32'h0800_0000);
    chan_irq = 15'h0800;
    rd_all("R4 ch11");
    chan_irq = 15'h4000;
    rd_all("R4 ch14");
    chan_irq = 15'h2000;
    rd_all("R4 ch13");

    chan_irq = 15'h0000;
    rd_all("R9 flag dropped");

    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'hFE0, 32'hFFFF_FFFF);
    rd(12'h010, {4'b0, en_m, 16'b0}, "R10 stray writes ignored");

    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, 32'h0FFF_0000, "R6 out-of-field bits dropped");
    chan_irq = 15'h7FFF;
    rd_all("R5 all flags");

    wr(12'h01C, 32'h0800_0001);
    rd(12'h010, 32'h07FF_0000, "R7 clear line 11");
    chan_irq = 15'h4000;
    rd_all("R7 shared line masked");

    wr(12'h01C, 32'hFFFF_FFFF);
    chan_irq = 15'h7FFF;
    rd_all("R7 all cleared");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errs++;
      $display("FAIL R10 missing reads actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule